// File: doc/BRIEF.md
# CPU core power-down sequencer

This block takes one core of a four-core cluster out of service in a fixed, safe order. A requester pulses a start input together with a one-hot core select. The controller accepts the request only when it is idle and the select names exactly one core. It then watches that core's wait-for-interrupt (WFI) status line and polls it without any timeout. When the core reports WFI, the controller sets the core's output clamp, pulls the core's active-low reset low and sets the core's 8-bit power switch control to all-off. Each of these outputs changes on its own clock cycle, in that order.

Core 0 is handled differently. Its clamp would isolate far more than the core itself, so for core 0 the clamp step is left out and the sequence goes straight from WFI to reset. A one-cycle release pulse ends every sequence and tells other requesters that the controller is free again. The clamp, reset and switch outputs are held in registers inside the block. They keep their values from earlier sequences, so cores are powered down one after another.

Top module: `core_pwrdn_seq`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), clamp_o is 4'b0000, core_rst_n_o is 4'b1111, every pwr_sw_o field is 8'h00, and busy_o and release_o are 0.
- R2: A start_i pulse, sampled while idle with sel_i one-hot (bit i selects core i), raises busy_o from the next cycle on. busy_o stays high until the cycle after the release pulse.
- R3: While busy, the block waits with no timeout until wfi_i bit i of the selected core is 1. WFI bits of other cores have no effect, and no output other than busy_o changes while it waits.
- R4: For a selected core other than 0, the cycle after WFI is seen, clamp_o bit i becomes 1. All other clamp bits keep their values.
- R5: For core 0 the clamp step is skipped: clamp_o bit 0 is never set, and the reset step follows WFI directly.
- R6: One cycle after the clamp step (or after WFI for core 0), core_rst_n_o bit i becomes 0. All other reset bits keep their values.
- R7: One cycle after the reset step, pwr_sw_o[8*i+7:8*i] becomes 8'hFF. The other switch fields keep their values.
- R8: One cycle after the switch step, release_o is 1 for exactly one cycle. busy_o falls in the following cycle.
- R9: A start_i pulse that arrives while busy is ignored. The sequence in progress completes for its original core, and no other core's outputs change.
- R10: A start_i pulse with sel_i not exactly one-hot (zero bits or two or more bits set) is rejected. busy_o stays 0 and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| sel_i | input | 4 | One-hot core select, bit i = core i |
| wfi_i | input | 4 | Per-core WFI status, bit i = core i |
| clamp_o | output | 4 | Per-core output clamp enable |
| core_rst_n_o | output | 4 | Per-core reset, active low |
| pwr_sw_o | output | 32 | Per-core 8-bit power switch control, core i at bits 8*i+7:8*i |
| busy_o | output | 1 | Sequence in progress |
| release_o | output | 1 | One-cycle pulse: controller free again |

## Verification
The bench puts core 0 through the sequence and checks that its clamp stays low and that reset follows WFI one cycle earlier than for the other cores. A design that applied the clamp uniformly would set clamp bit 0 and shift every later step by a cycle. The bench toggles the WFI bits of cores that are not selected during long waits. A design that OR-reduced the whole WFI bus would start early, and a design with a hidden timeout would end a long wait on its own. The bench also sends extra starts while busy and starts with zero-bit and multi-bit masks. These expose a design that relatches the select or acts on a malformed mask, because another core's clamp, reset or switch field would change. Each step is sampled in its own cycle, so steps that merge or swap order show up as a mismatch.

// File: rtl/pwrdn_pkg.sv
// pwrdn_pkg: shared types for the core power-down sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pwrdn_pkg;

    // Sequencer phases, visited in this order (CLAMP skipped for core 0).
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CLAMP,
        ST_RESET,
        ST_SWITCH,
        ST_RELEASE
    } seq_state_t;

endpackage

// File: rtl/pwrdn_sel_decode.sv
// pwrdn_sel_decode: checks that a core select mask is exactly one-hot and
// returns the index of its set bit.
// Assumes: idx_o is meaningful only when onehot_o is 1.
module pwrdn_sel_decode #(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int CNT_W  = $clog2(N_CORES + 1)
) (
    input  logic [N_CORES-1:0] mask_i,
    output logic               onehot_o,
    output logic [IDX_W-1:0]   idx_o
);

    logic [CNT_W-1:0] ones;

    // Count set bits and remember the position of the last one found.
    always_comb begin
        ones  = '0;
        idx_o = '0;
        for (int i = 0; i < N_CORES; i++) begin
            if (mask_i[i]) begin
                ones  = ones + CNT_W'(1);
                idx_o = IDX_W'(i);
            end
        end
        onehot_o = (ones == CNT_W'(1));
    end

endmodule

// File: rtl/pwrdn_fsm.sv
// pwrdn_fsm: ordered power-down sequencer. It accepts a request when idle,
// waits for WFI of the latched core, then issues clamp, reset and switch
// strobes on successive cycles and ends with a release state.
// Assumes: sel_ok_i and sel_idx_i are decoded from sel_i in the same cycle.
// The strobes are issued on the transition into a step, so each step's
// output is visible during that step's own state.
module pwrdn_fsm
    import pwrdn_pkg::*;
#(
    parameter int N_CORES = 4,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [N_CORES-1:0] sel_i,
    input  logic               sel_ok_i,
    input  logic [IDX_W-1:0]   sel_idx_i,
    input  logic [N_CORES-1:0] wfi_i,
    output logic [N_CORES-1:0] sel_q_o,
    output logic [IDX_W-1:0]   idx_q_o,
    output logic               do_clamp_o,
    output logic               do_reset_o,
    output logic               do_switch_o,
    output logic               busy_o,
    output logic               release_o
);

    seq_state_t state_q, state_d;
    logic       wfi_hit;
    logic       accept;

    assign wfi_hit = |(wfi_i & sel_q_o);
    assign accept  = (state_q == ST_IDLE) && start_i && sel_ok_i;

    // Next-state and step-strobe selection.
    always_comb begin
        state_d     = state_q;
        do_clamp_o  = 1'b0;
        do_reset_o  = 1'b0;
        do_switch_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (wfi_hit) begin
                    if (sel_q_o[0]) begin
                        state_d    = ST_RESET;
                        do_reset_o = 1'b1;
                    end else begin
                        state_d    = ST_CLAMP;
                        do_clamp_o = 1'b1;
                    end
                end
            end
            ST_CLAMP: begin
                state_d    = ST_RESET;
                do_reset_o = 1'b1;
            end
            ST_RESET: begin
                state_d     = ST_SWITCH;
                do_switch_o = 1'b1;
            end
            ST_SWITCH:  state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the selected core only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q_o <= '0;
            idx_q_o <= '0;
        end else if (accept) begin
            sel_q_o <= sel_i;
            idx_q_o <= sel_idx_i;
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign release_o = (state_q == ST_RELEASE);

    // R3: without WFI on the selected core the sequencer keeps waiting.
    a_r3_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !(|(wfi_i & sel_q_o))) |=> (state_q == ST_WAIT));

    // R2: an accepted request makes the block busy on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && sel_ok_i) |=> busy_o);

    // R8: release lasts one cycle and is followed by idle.
    a_r8_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> (!release_o && !busy_o));

    // R9: the latched core does not change while a sequence runs.
    a_r9_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !release_o) |=> $stable(sel_q_o));

    // R10: a malformed mask leaves the sequencer idle.
    a_r10_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && !sel_ok_i) |=> !busy_o);

endmodule

// File: rtl/pwrdn_out_bank.sv
// pwrdn_out_bank: per-core clamp, reset and power switch registers. Each
// strobe changes only the fields of the latched core.
// Assumes: at most one strobe is high per cycle, and sel_i is one-hot and
// matches idx_i whenever a strobe is high.
module pwrdn_out_bank #(
    parameter int          N_CORES = 4,
    parameter int          SW_W    = 8,
    parameter logic [SW_W-1:0] SW_OFF = '1,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_CORES-1:0]      sel_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic                    do_clamp_i,
    input  logic                    do_reset_i,
    input  logic                    do_switch_i,
    output logic [N_CORES-1:0]      clamp_o,
    output logic [N_CORES-1:0]      core_rst_n_o,
    output logic [N_CORES*SW_W-1:0] pwr_sw_o
);

    for (genvar g = 0; g < N_CORES; g++) begin : g_core

        // Clamp enable: set once by the clamp strobe, never cleared here.
        always_ff @(posedge clk) begin
            if (!rst_n)                       clamp_o[g] <= 1'b0;
            else if (do_clamp_i && sel_i[g])  clamp_o[g] <= 1'b1;
        end

        // Active-low core reset: pulled low by the reset strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)                       core_rst_n_o[g] <= 1'b1;
            else if (do_reset_i && sel_i[g])  core_rst_n_o[g] <= 1'b0;
        end

        // Power switch field: written to all-off, selected by core number.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pwr_sw_o[g*SW_W +: SW_W] <= '0;
            else if (do_switch_i && (idx_i == IDX_W'(g)))
                pwr_sw_o[g*SW_W +: SW_W] <= SW_OFF;
        end
    end

    // R4: a core other than 0 is clamped before its reset is pulled.
    a_r4_clamp_before_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (do_reset_i && idx_i != '0) |-> clamp_o[idx_i]);

    // R4: clamp bits never fall while running.
    a_r4_clamp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((clamp_o & $past(clamp_o)) == $past(clamp_o)));

    // R5: core 0 is never clamped.
    a_r5_core0_unclamped: assert property (@(posedge clk) disable iff (!rst_n)
        !clamp_o[0]);

    // R6: at most one core reset falls in any cycle.
    a_r6_single_reset_fall: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $onehot0($past(core_rst_n_o) & ~core_rst_n_o));

    // R7: power is switched off only for a core already held in reset.
    a_r7_switch_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        do_switch_i |-> !core_rst_n_o[idx_i]);

endmodule

// File: rtl/core_pwrdn_seq.sv
// core_pwrdn_seq: top of the core power-down sequencer. It decodes the
// select mask, runs the ordered sequence and holds the per-core outputs.
// Assumes: synchronous active-low reset; wfi_i is synchronous to clk.
module core_pwrdn_seq #(
    parameter int              N_CORES = 4,
    parameter int              SW_W    = 8,
    parameter logic [SW_W-1:0] SW_OFF  = 8'hFF,
    localparam int IDX_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [N_CORES-1:0]      sel_i,
    input  logic [N_CORES-1:0]      wfi_i,
    output logic [N_CORES-1:0]      clamp_o,
    output logic [N_CORES-1:0]      core_rst_n_o,
    output logic [N_CORES*SW_W-1:0] pwr_sw_o,
    output logic                    busy_o,
    output logic                    release_o
);

    logic               sel_ok;
    logic [IDX_W-1:0]   sel_idx;
    logic [N_CORES-1:0] sel_q;
    logic [IDX_W-1:0]   idx_q;
    logic               do_clamp;
    logic               do_reset;
    logic               do_switch;

    pwrdn_sel_decode #(.N_CORES(N_CORES)) u_decode (
        .mask_i   (sel_i),
        .onehot_o (sel_ok),
        .idx_o    (sel_idx)
    );

    pwrdn_fsm #(.N_CORES(N_CORES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sel_i       (sel_i),
        .sel_ok_i    (sel_ok),
        .sel_idx_i   (sel_idx),
        .wfi_i       (wfi_i),
        .sel_q_o     (sel_q),
        .idx_q_o     (idx_q),
        .do_clamp_o  (do_clamp),
        .do_reset_o  (do_reset),
        .do_switch_o (do_switch),
        .busy_o      (busy_o),
        .release_o   (release_o)
    );

    pwrdn_out_bank #(
        .N_CORES (N_CORES),
        .SW_W    (SW_W),
        .SW_OFF  (SW_OFF)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (sel_q),
        .idx_i        (idx_q),
        .do_clamp_i   (do_clamp),
        .do_reset_i   (do_reset),
        .do_switch_i  (do_switch),
        .clamp_o      (clamp_o),
        .core_rst_n_o (core_rst_n_o),
        .pwr_sw_o     (pwr_sw_o)
    );

    // R1: the outputs hold their reset values in the cycle after reset.
    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (clamp_o == '0 && core_rst_n_o == '1 && pwr_sw_o == '0
                    && !busy_o && !release_o));

endmodule

// File: tb/core_pwrdn_seq_tb_top.sv
`timescale 1ns/1ps
// core_pwrdn_seq_tb_top: self-checking bench. Random sequences from a fixed
// seed are mixed with directed corner cases and compared against expected
// values that bench functions compute.
module core_pwrdn_seq_tb_top;

    localparam int N  = 4;
    localparam int SW = 8;
    localparam int WATCHDOG_CYCLES = 100000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic [N-1:0]    sel_i = '0;
    logic [N-1:0]    wfi_i = '0;
    logic [N-1:0]    clamp_o;
    logic [N-1:0]    core_rst_n_o;
    logic [N*SW-1:0] pwr_sw_o;
    logic            busy_o;
    logic            release_o;

    logic [N-1:0]    exp_clamp;
    logic [N-1:0]    exp_rst;
    logic [N*SW-1:0] exp_sw;
    logic            exp_busy;
    logic            exp_rel;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    core_pwrdn_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sel_i        (sel_i),
        .wfi_i        (wfi_i),
        .clamp_o      (clamp_o),
        .core_rst_n_o (core_rst_n_o),
        .pwr_sw_o     (pwr_sw_o),
        .busy_o       (busy_o),
        .release_o    (release_o)
    );

    function automatic logic [N-1:0] f_set(logic [N-1:0] v, int i);
        logic [N-1:0] r = v;
        r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [N-1:0] f_clr(logic [N-1:0] v, int i);
        logic [N-1:0] r = v;
        r[i] = 1'b0;
        return r;
    endfunction

    function automatic logic [N*SW-1:0] f_sw_off(logic [N*SW-1:0] v, int i);
        logic [N*SW-1:0] r = v;
        r[i*SW +: SW] = 8'hFF;
        return r;
    endfunction

    // Compare every output with its expected value; one check per call.
    task automatic check_all(string req);
        checks++;
        if (clamp_o !== exp_clamp || core_rst_n_o !== exp_rst || pwr_sw_o !== exp_sw
            || busy_o !== exp_busy || release_o !== exp_rel) begin
            failures++;
            $display("FAIL %s: clamp=%b rst_n=%b sw=%h busy=%b rel=%b expected clamp=%b rst_n=%b sw=%h busy=%b rel=%b",
                     req, clamp_o, core_rst_n_o, pwr_sw_o, busy_o, release_o,
                     exp_clamp, exp_rst, exp_sw, exp_busy, exp_rel);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; wfi_i = '0; sel_i = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_clamp = '0; exp_rst = '1; exp_sw = '0; exp_busy = 1'b0; exp_rel = 1'b0;
        check_all("R1");
    endtask

    // One full power-down of core idx; WFI rises after d waiting cycles (d >= 1).
    task automatic do_seq(int idx, int d, bit poke);
        logic [N-1:0] m = N'(1) << idx;
        @(negedge clk);
        sel_i = m; start_i = 1'b1; wfi_i = N'($urandom) & ~m;
        for (int k = 1; k <= d; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            exp_busy = 1'b1;
            check_all(k == 1 ? "R2" : "R3");
            wfi_i = (N'($urandom) & ~m) | ((k == d) ? m : '0);
            if (poke && k == 1) begin
                start_i = 1'b1;
                sel_i   = N'(1) << ((idx + 1) % N);
            end
        end
        @(negedge clk);
        start_i = 1'b0;
        if (idx != 0) begin
            exp_clamp = f_set(exp_clamp, idx);
            check_all(poke ? "R4 R9" : "R4");
            @(negedge clk);
        end
        exp_rst = f_clr(exp_rst, idx);
        check_all(idx == 0 ? "R5 R6" : "R6");
        @(negedge clk);
        exp_sw = f_sw_off(exp_sw, idx);
        check_all("R7");
        @(negedge clk);
        exp_rel = 1'b1;
        check_all("R8");
        @(negedge clk);
        exp_rel = 1'b0; exp_busy = 1'b0;
        check_all(poke ? "R8 R9" : "R8");
        wfi_i = '0;
    endtask

    // Start with a malformed mask; nothing may change for three cycles.
    task automatic do_reject(logic [N-1:0] bad);
        @(negedge clk);
        sel_i = bad; start_i = 1'b1; wfi_i = '1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 3; k++) begin
            check_all("R10");
            @(negedge clk);
        end
        wfi_i = '0;
    endtask

    function automatic logic [N-1:0] f_bad_mask();
        logic [N-1:0] v;
        do v = N'($urandom); while ($countones(v) == 1);
        return v;
    endfunction

    initial begin
        void'($urandom(32'd4711));
        exp_clamp = '0; exp_rst = '1; exp_sw = '0; exp_busy = 1'b0; exp_rel = 1'b0;
        do_reset();
        // Directed corner cases.
        do_reject('0);
        do_reject(4'b0110);
        do_seq(0, 1, 1'b0);           // R5: core 0, WFI already there
        do_seq(3, 1, 1'b0);
        do_seq(1, 5, 1'b1);           // R9: start while busy
        do_seq(2, 40, 1'b0);          // R3: long wait, no timeout
        do_reject(4'b1111);
        do_seq(2, 2, 1'b0);           // same core again: idempotent
        do_reset();
        // Random mix.
        for (int n = 0; n < 30; n++) begin
            int sel = int'($urandom % 8);
            if (sel == 0)      do_reject(f_bad_mask());
            else if (sel == 1) do_reset();
            else do_seq(int'($urandom % N), 1 + int'($urandom % 8), 1'($urandom));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule